// File: doc/BRIEF.md
# Successive-Approximation Error-Rate Calibration Controller

This controller tunes a 6-bit delay code so that an intentionally unreliable parity bit disagrees with its reliable twin at a chosen rate. Each query strobe captures both parity bits in flip-flops. Their XOR is a mismatch event, and a saturating counter counts these events over a fixed window of 1024 queries. One window is one search step. At the end of a step the count is compared with a programmable target, and this comparison settles one bit of the code.

The search runs seven steps. The first step measures with the code at all zeros. That measurement is not used in any decision, and the step ends by setting the most significant bit as a trial. Each later step judges the bit under trial and then sets the next lower bit as the new trial. After the step that judges bit 0, the controller locks. From then on it holds the code, raises its lock flag, and ignores both parity inputs. A larger code means more delay and so fewer mismatches. The search therefore settles on the largest code whose window count still reaches the target.

Top module: `errcal_top`

## Requirements
- R1: While reset is low and just after it is released, the code output is 0 and the lock flag is 0.
- R2: The two parity inputs are sampled only in a cycle where the query strobe is high. A query counts as one mismatch when the two sampled values differ.
- R3: One step spans exactly 1024 queries. The mismatch count starts from zero at the beginning of every step.
- R4: The mismatch count saturates at 1023 and does not wrap. A window in which all 1024 queries mismatch therefore counts as 1023.
- R5: During the first step the code is 0. After the first step's 1024 queries the code is 6'b100000.
- R6: A bit under trial stays at 1 when its step's count is greater than or equal to the target. It returns to 0 when the count is below the target.
- R7: When the mismatch count falls as the code rises, the final code is the largest code whose window count is greater than or equal to the target. If no code meets the target, the final code is 0.
- R8: The lock flag is 0 before the 7168th query and is 1 within three cycles after that query's strobe.
- R9: Once the lock flag is set, the code and the lock flag hold their values whatever queries and parity values arrive, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| queryStb | input | 1 | One-cycle pulse marking one query |
| parityErr | input | 1 | Parity sampled through the adjustable delay |
| parityRef | input | 1 | Reliable parity used as the reference during calibration |
| targetCnt | input | 10 | Mismatch count the search aims for per window |
| ctrlCode | output | 6 | Delay control code |
| locked | output | 1 | High once the search has finished and the code is frozen |

## Verification
The case hardest to reach from the ports is a step whose window fills the counter completely. Only a run of 1024 consecutive mismatches exposes the difference between saturating and wrapping. The bench reaches it with a delay model that mismatches on every query, paired with a target of 1023, so a wrapped count would clear every trial bit. The other runs feed a randomly sloped falling error curve with random parity polarity and random targets. A reference search picks the expected code, and queries after lock check that the frozen code ignores its inputs.

// File: rtl/errcal_pkg.sv
package errcal_pkg;
  // strobes from the control sequencer to the counting datapath
  typedef struct packed {
    logic runEn;    // capture and count queries (calibration active)
  } ctlStrb_t;
endpackage

// File: rtl/errcal_datapath.sv
module errcal_datapath
  import errcal_pkg::*;
#(
  parameter int WIN   = 1024,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         ctl,
  input  logic             queryStb,
  input  logic             parityErr,
  input  logic             parityRef,
  output logic             stepDone,
  output logic [CNT_W-1:0] stepCnt
);
  localparam int QW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [QW-1:0]    Q_LAST  = QW'(WIN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic capErr, capRef, capVld;
  logic [CNT_W-1:0] errCnt, errNext;
  logic [QW-1:0] qCnt;
  logic mis, lastQ;

  // capture stage: one flop per parity bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capErr <= 1'b0;
      capRef <= 1'b0;
      capVld <= 1'b0;
    end else begin
      capVld <= queryStb & ctl.runEn;
      if (queryStb && ctl.runEn) begin
        capErr <= parityErr;
        capRef <= parityRef;
      end
    end
  end

  assign mis   = capErr ^ capRef;
  assign lastQ = capVld && (qCnt == Q_LAST);

  always_comb begin
    errNext = errCnt;
    if (mis && (errCnt != CNT_MAX)) errNext = errCnt + CNT_W'(1);
  end

  // window counter and saturating mismatch counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCnt   <= '0;
      qCnt     <= '0;
      stepCnt  <= '0;
      stepDone <= 1'b0;
    end else begin
      stepDone <= 1'b0;
      if (capVld) begin
        if (lastQ) begin
          stepCnt  <= errNext;
          stepDone <= 1'b1;
          errCnt   <= '0;
          qCnt     <= '0;
        end else begin
          errCnt <= errNext;
          qCnt   <= qCnt + QW'(1);
        end
      end
    end
  end

  // R4
  cntSat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capVld && !lastQ && errCnt == CNT_MAX) |=> (errCnt == CNT_MAX));

  // R2
  cntStep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capVld && !lastQ && errCnt != CNT_MAX) |=>
      (errCnt == $past(errCnt) + CNT_W'($past(mis))));

  // R9
  noCapture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.runEn) |=> !capVld);
endmodule

// File: rtl/errcal_fsm.sv
module errcal_fsm
  import errcal_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepDone,
  input  logic [CNT_W-1:0]  stepCnt,
  input  logic [CNT_W-1:0]  targetCnt,
  output ctlStrb_t          ctl,
  output logic [CODE_W-1:0] ctrlCode,
  output logic              locked
);
  localparam int SW = $clog2(CODE_W + 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(CODE_W);

  logic [SW-1:0] step;
  logic [CODE_W-1:0] curBit, newBit, codeNext;

  // curBit: bit judged at the end of this step; newBit: next trial bit
  always_comb begin
    curBit = '0;
    newBit = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (int'(step) == CODE_W - i)     curBit[i] = 1'b1;
      if (int'(step) == CODE_W - 1 - i) newBit[i] = 1'b1;
    end
    codeNext = ctrlCode | newBit;
    if (stepCnt < targetCnt) codeNext = codeNext & ~curBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step     <= '0;
      ctrlCode <= '0;
      locked   <= 1'b0;
    end else if (stepDone && !locked) begin
      ctrlCode <= codeNext;
      if (step == LAST_STEP) locked <= 1'b1;
      else                   step   <= step + SW'(1);
    end
  end

  assign ctl.runEn = !locked;

  // R9
  lockHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> (locked && $stable(ctrlCode)));

  // R8
  lockStep_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (step == LAST_STEP));

  // R5
  msbTrial_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepDone && !locked && step == '0) |=>
      (ctrlCode == {1'b1, {(CODE_W-1){1'b0}}}));

  // R6
  keepRule_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepDone && !locked && step != '0 && stepCnt >= targetCnt) |=>
      ((ctrlCode & $past(curBit)) != '0));
endmodule

// File: rtl/errcal_top.sv
module errcal_top
  import errcal_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int WIN    = 1024,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              queryStb,
  input  logic              parityErr,
  input  logic              parityRef,
  input  logic [CNT_W-1:0]  targetCnt,
  output logic [CODE_W-1:0] ctrlCode,
  output logic              locked
);
  ctlStrb_t ctl;
  logic stepDone;
  logic [CNT_W-1:0] stepCnt;

  errcal_datapath #(.WIN(WIN), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .queryStb(queryStb),
    .parityErr(parityErr), .parityRef(parityRef),
    .stepDone(stepDone), .stepCnt(stepCnt)
  );

  errcal_fsm #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rstN(rstN), .stepDone(stepDone), .stepCnt(stepCnt),
    .targetCnt(targetCnt), .ctl(ctl), .ctrlCode(ctrlCode), .locked(locked)
  );
endmodule

// File: tb/errcal_top_bench.sv
module errcal_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic queryStb = 1'b0;
  logic parityErr = 1'b0;
  logic parityRef = 1'b0;
  logic [9:0] targetCnt = '0;
  logic [5:0] ctrlCode;
  logic locked;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  // delay-line model parameters
  int base, slope;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  errcal_top u_errcal_top (
    .clk(clk), .rstN(rstN), .queryStb(queryStb), .parityErr(parityErr),
    .parityRef(parityRef), .targetCnt(targetCnt),
    .ctrlCode(ctrlCode), .locked(locked)
  );

  function automatic int errModel(int code);
    int v = base - slope * code;
    if (v < 0) v = 0;
    if (v > 1024) v = 1024;
    return v;
  endfunction

  // saturated window count as the requirement (R4) defines it
  function automatic int satCnt(int code);
    int v = errModel(code);
    return (v > 1023) ? 1023 : v;
  endfunction

  function automatic int refCode(int tgt);
    for (int c = 63; c >= 0; c--)
      if (satCnt(c) >= tgt) return c;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic query(bit e, bit r);
    @(negedge clk);
    queryStb = 1'b1; parityErr = e; parityRef = r;
    @(negedge clk);
    queryStb = 1'b0;
    parityErr = $urandom % 2; parityRef = $urandom % 2;   // R2 off-strobe noise
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runCal(int b, int s, int tgt);
    int cnt;
    base = b; slope = s; targetCnt = 10'(tgt);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 code in reset", ctrlCode, 0);
    check("R1 locked in reset", locked, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 code after reset", ctrlCode, 0);
    for (int w = 0; w < 7; w++) begin
      if (w == 0) check("R5 code in first step", ctrlCode, 0);
      cnt = errModel(ctrlCode);
      for (int q = 0; q < 1024; q++) begin
        bit r = $urandom % 2;
        if (w == 6 && q == 1023) check("R8 locked before last query", locked, 0);
        query(r ^ (q < cnt), r);
      end
      if (w == 0) check("R5 code after first step", ctrlCode, 32);
    end
    check("R8 locked after 7 steps", locked, 1);
    check("R7 R6 R3 final code", ctrlCode, refCode(tgt));
    // R9: after lock, parity inputs have no effect
    begin
      int held = ctrlCode;
      for (int q = 0; q < 24; q++) query($urandom % 2, $urandom % 2);
      check("R9 code held after lock", ctrlCode, held);
      check("R9 locked held", locked, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R4: every query mismatches, 1024 saturates to 1023 >= target 1023
    runCal(1024, 0, 1023);
    // R7: no code reaches the target -> code 0
    runCal(900, 10, 1000);
    // R6 R7: random falling curves
    for (int k = 0; k < 2; k++) begin
      int b = 200 + ($urandom % 825);
      int s = 1 + ($urandom % 30);
      int t = 1 + ($urandom % b);
      if (t > 1023) t = 1023;
      runCal(b, s, t);
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 195000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule